// File: doc/BRIEF.md
# Move-Only Transport Processor Core

This block is a very small processor with exactly one instruction: copy one data byte from a source address to a destination address. It has no opcode field. Every instruction is four bytes in instruction memory, giving a 16-bit source address and then a 16-bit destination address. Arithmetic, I/O and any other effect come only from reading or writing addresses that other logic maps onto those functions. There is no immediate operand. A constant is stored at some address and moved from there.

A sequencer runs four machine cycles in a fixed order. It fetches the source address, reads the source byte into a hold register, fetches the destination address, and then writes the held byte. The two address fetches take two clocks each, one per byte. The read and the write take one clock each, so in free-running mode an instruction takes six clocks.

In single-step mode the core advances by one machine cycle for each press of a step input. Pointer-style indirection is done in software by self-modifying code: a move writes a new address byte into a later instruction. The core never prefetches, so a patched byte is used when its instruction runs.

Top module: `xferCpu`

## Requirements
- R1: Each instruction occupies four consecutive instruction bytes, in this order: source high, source low, destination high, destination low. The instruction copies the byte at the source address to the destination address.
- R2: Within one instruction the source is read before the destination is written. A move whose source and destination are the same address leaves that byte unchanged. A move that reads the destination of the previous move sees that move's result.
- R3: The instruction address is {pcHigh, pcLow}. It increases by one after every instruction byte fetch, and a carry passes from the low half into the high half. After one instruction it has advanced by four.
- R4: The byte written is the value captured in the read cycle, even if the source location changes between the read and the write.
- R5: The write strobe is high for exactly one clock per instruction, in the deposit cycle. The read strobe is high for exactly one clock per instruction. The two are never high together.
- R6: In free-running mode an instruction takes exactly six clocks: two for each address fetch, one for the read and one for the write.
- R7: In single-step mode the core does nothing until a rising edge of the step input. Each rising edge completes exactly one machine cycle. Holding the step input high counts as one press.
- R8: While reset is high, the instruction address is zero and neither data strobe is asserted. After reset is released, execution starts with the source address fetch of the instruction at address zero.
- R9: A move that writes into a later instruction's address bytes changes the address that instruction uses, because instruction bytes are fetched only when they are executed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| stepMode | input | 1 | 1 = advance one machine cycle per step press |
| stepIn | input | 1 | Step button level; each rising edge is one press |
| imemAddr | output | 16 | Instruction byte address (program counter) |
| imemData | input | 8 | Instruction byte at imemAddr, read combinationally |
| dmemAddr | output | 16 | Data address: source during the read, destination during the write |
| dmemRdata | input | 8 | Data byte at dmemAddr, read combinationally |
| dmemWdata | output | 8 | Held byte being deposited |
| dmemRd | output | 1 | Read strobe, one clock per instruction |
| dmemWr | output | 1 | Write strobe, one clock per instruction |

## Verification
The hardest case to reach is the gap between the read and the write of a single instruction. In free-running mode that gap is only a few clocks, so nothing outside the core can change the source byte inside it. The bench therefore runs in single-step mode and stops the core right after the read cycle. It then overwrites the source byte through its own memory port and releases the write cycle, which shows that the held value is the one deposited. Self-modifying code is covered by a program whose first move patches the source address of the second. The low-to-high program counter carry is covered by running 64 instructions until the address crosses 0x00FF.

// File: rtl/xferPkg.sv
package xferPkg;

  typedef enum logic [1:0] {
    PH_FETCH_SRC = 2'd0,
    PH_READ      = 2'd1,
    PH_FETCH_DST = 2'd2,
    PH_WRITE     = 2'd3
  } phase_t;

  // Control strobes from the sequencer to the datapath
  typedef struct packed {
    logic [3:0] ldAddrByte; // 0 srcHi, 1 srcLo, 2 dstHi, 3 dstLo
    logic       incPc;
    logic       ldHold;
    logic       selDst;
    logic       rdEn;
    logic       wrEn;
  } ctlStrobes_t;

endpackage

// File: rtl/xferStepGate.sv
module xferStepGate (
  input  logic clk,
  input  logic rst,
  input  logic stepMode,
  input  logic stepIn,
  input  logic phaseDone,
  output logic advance
);

  logic stepPrev;
  logic armed;
  logic stepEdge;

  assign stepEdge = stepIn & ~stepPrev;
  assign advance  = ~stepMode | armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      stepPrev <= 1'b0;
      armed    <= 1'b0;
    end else begin
      stepPrev <= stepIn;
      if (phaseDone)
        armed <= 1'b0;
      else if (stepEdge)
        armed <= 1'b1;
    end
  end

endmodule

// File: rtl/xferCtrl.sv
module xferCtrl
  import xferPkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        advance,
  output ctlStrobes_t stb,
  output logic        phaseDone
);

  phase_t phase;
  logic   lowByte;  // 0 = high byte next, 1 = low byte next

  always_comb begin
    stb       = '0;
    phaseDone = 1'b0;
    stb.selDst = (phase == PH_FETCH_DST) || (phase == PH_WRITE);
    if (advance && !rst) begin
      unique case (phase)
        PH_FETCH_SRC: begin
          stb.incPc = 1'b1;
          if (lowByte) begin
            stb.ldAddrByte[1] = 1'b1;
            phaseDone         = 1'b1;
          end else begin
            stb.ldAddrByte[0] = 1'b1;
          end
        end
        PH_READ: begin
          stb.rdEn   = 1'b1;
          stb.ldHold = 1'b1;
          phaseDone  = 1'b1;
        end
        PH_FETCH_DST: begin
          stb.incPc = 1'b1;
          if (lowByte) begin
            stb.ldAddrByte[3] = 1'b1;
            phaseDone         = 1'b1;
          end else begin
            stb.ldAddrByte[2] = 1'b1;
          end
        end
        PH_WRITE: begin
          stb.wrEn  = 1'b1;
          phaseDone = 1'b1;
        end
        default: phaseDone = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_FETCH_SRC;
      lowByte <= 1'b0;
    end else if (advance) begin
      unique case (phase)
        PH_FETCH_SRC: begin
          lowByte <= ~lowByte;
          if (lowByte) phase <= PH_READ;
        end
        PH_READ:      phase <= PH_FETCH_DST;
        PH_FETCH_DST: begin
          lowByte <= ~lowByte;
          if (lowByte) phase <= PH_WRITE;
        end
        PH_WRITE:     phase <= PH_FETCH_SRC;
        default:      phase <= PH_FETCH_SRC;
      endcase
    end
  end

endmodule

// File: rtl/xferPath.sv
module xferPath
  import xferPkg::*;
#(
  parameter int HALF_W = 8,
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  ctlStrobes_t         stb,
  output logic [2*HALF_W-1:0] imemAddr,
  input  logic [HALF_W-1:0]   imemData,
  output logic [2*HALF_W-1:0] dmemAddr,
  input  logic [DATA_W-1:0]   dmemRdata,
  output logic [DATA_W-1:0]   dmemWdata
);

  localparam int ADDR_W    = 2 * HALF_W;
  localparam int NUM_BYTES = 4;

  logic [HALF_W-1:0] pcLow, pcHigh;
  logic [HALF_W-1:0] pcLowNext;
  logic              pcCarry;
  logic [HALF_W-1:0] addrByte [NUM_BYTES];
  logic [DATA_W-1:0] holdReg;
  logic [ADDR_W-1:0] srcAddr, dstAddr;

  assign {pcCarry, pcLowNext} = {1'b0, pcLow} + {{HALF_W{1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst) begin
      pcLow  <= '0;
      pcHigh <= '0;
    end else if (stb.incPc) begin
      pcLow <= pcLowNext;
      if (pcCarry) pcHigh <= pcHigh + {{(HALF_W-1){1'b0}}, 1'b1};
    end
  end

  for (genvar i = 0; i < NUM_BYTES; i++) begin : g_addrByte
    always_ff @(posedge clk) begin
      if (rst)
        addrByte[i] <= '0;
      else if (stb.ldAddrByte[i])
        addrByte[i] <= imemData;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      holdReg <= '0;
    else if (stb.ldHold)
      holdReg <= dmemRdata;
  end

  assign srcAddr   = {addrByte[0], addrByte[1]};
  assign dstAddr   = {addrByte[2], addrByte[3]};
  assign imemAddr  = {pcHigh, pcLow};
  assign dmemAddr  = stb.selDst ? dstAddr : srcAddr;
  assign dmemWdata = holdReg;

endmodule

// File: rtl/xferCpu.sv
module xferCpu
  import xferPkg::*;
#(
  parameter int HALF_W = 8,
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                stepMode,
  input  logic                stepIn,
  output logic [2*HALF_W-1:0] imemAddr,
  input  logic [HALF_W-1:0]   imemData,
  output logic [2*HALF_W-1:0] dmemAddr,
  input  logic [DATA_W-1:0]   dmemRdata,
  output logic [DATA_W-1:0]   dmemWdata,
  output logic                dmemRd,
  output logic                dmemWr
);

  ctlStrobes_t stb;
  logic        advance;
  logic        phaseDone;

  xferStepGate u_gate (
    .clk       (clk),
    .rst       (rst),
    .stepMode  (stepMode),
    .stepIn    (stepIn),
    .phaseDone (phaseDone),
    .advance   (advance)
  );

  xferCtrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .advance   (advance),
    .stb       (stb),
    .phaseDone (phaseDone)
  );

  xferPath #(.HALF_W(HALF_W), .DATA_W(DATA_W)) u_path (
    .clk       (clk),
    .rst       (rst),
    .stb       (stb),
    .imemAddr  (imemAddr),
    .imemData  (imemData),
    .dmemAddr  (dmemAddr),
    .dmemRdata (dmemRdata),
    .dmemWdata (dmemWdata)
  );

  assign dmemRd = stb.rdEn;
  assign dmemWr = stb.wrEn;

endmodule

// File: rtl/xferCpuChk.sv
module xferCpuChk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] imemAddr,
  input logic              dmemRd,
  input logic              dmemWr
);

  // R5: a write strobe lasts one clock
  p_wr_single_r5: assert property (@(posedge clk) disable iff (rst)
    dmemWr |=> !dmemWr);

  // R5: read and write never overlap
  p_rd_wr_excl_r5: assert property (@(posedge clk) disable iff (rst)
    !(dmemRd && dmemWr));

  // R8: no strobes while reset is held
  p_quiet_reset_r8: assert property (@(posedge clk)
    rst |-> (!dmemWr && !dmemRd));

  // R3: the program counter only ever steps by one
  p_pc_step_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && imemAddr != $past(imemAddr)) |->
      imemAddr == $past(imemAddr) + 1'b1);

  // R2: no byte fetch happens in the read cycle
  p_read_holds_pc_r2: assert property (@(posedge clk) disable iff (rst)
    dmemRd |=> $stable(imemAddr));

endmodule

bind xferCpu xferCpuChk #(.ADDR_W(2*HALF_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .imemAddr (imemAddr),
  .dmemRd   (dmemRd),
  .dmemWr   (dmemWr)
);

// File: tb/tb_xferCpu.sv
module tb_xferCpu;

  localparam int CLK_PERIOD = 10;
  localparam int MEM_BITS   = 12;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        stepMode = 1'b0;
  logic        stepIn = 1'b0;
  logic [15:0] imemAddr, dmemAddr;
  logic [7:0]  imemData, dmemRdata, dmemWdata;
  logic        dmemRd, dmemWr;

  logic [7:0]  mem [0:(1<<MEM_BITS)-1];
  logic        tbWe = 1'b0;
  logic        tbClr = 1'b0;
  logic [15:0] tbAddr = '0;
  logic [7:0]  tbData = '0;

  int checks = 0;
  int failures = 0;
  int monFail = 0;
  int wrCount = 0;
  int rdCount = 0;
  logic prevWr = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xferCpu dut (
    .clk(clk), .rst(rst), .stepMode(stepMode), .stepIn(stepIn),
    .imemAddr(imemAddr), .imemData(imemData),
    .dmemAddr(dmemAddr), .dmemRdata(dmemRdata), .dmemWdata(dmemWdata),
    .dmemRd(dmemRd), .dmemWr(dmemWr)
  );

  // Unified memory: instruction and data share one array
  assign imemData  = mem[imemAddr[MEM_BITS-1:0]];
  assign dmemRdata = mem[dmemAddr[MEM_BITS-1:0]];

  always @(posedge clk) begin
    if (tbClr) begin
      for (int i = 0; i < (1<<MEM_BITS); i++) mem[i] <= 8'h00;
    end else if (dmemWr) begin
      mem[dmemAddr[MEM_BITS-1:0]] <= dmemWdata;
    end else if (tbWe) begin
      mem[tbAddr[MEM_BITS-1:0]] <= tbData;
    end
  end

  // Strobe monitor (R5)
  always @(negedge clk) begin
    if (!rst) begin
      if (dmemWr) wrCount++;
      if (dmemRd) rdCount++;
      if (dmemWr && prevWr) begin
        monFail++;
        $display("FAIL R5: write strobe high two clocks in a row (actual 2, expected 1)");
      end
      if (dmemWr && dmemRd) begin
        monFail++;
        $display("FAIL R5: read and write strobes together (actual 1, expected 0)");
      end
    end
    prevWr = dmemWr;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog: run did not finish (actual timeout, expected completion)");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures + monFail);
    $finish;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic clocks(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic poke(input logic [15:0] a, input logic [7:0] d);
    tbAddr = a; tbData = d; tbWe = 1'b1;
    @(posedge clk); @(negedge clk);
    tbWe = 1'b0;
  endtask

  task automatic putInstr(input int idx, input logic [15:0] src, input logic [15:0] dst);
    poke(16'(idx*4 + 0), src[15:8]);
    poke(16'(idx*4 + 1), src[7:0]);
    poke(16'(idx*4 + 2), dst[15:8]);
    poke(16'(idx*4 + 3), dst[7:0]);
  endtask

  // Hold reset, clear memory; caller loads program then calls release
  task automatic enterReset(input logic stepSel);
    @(negedge clk);
    rst = 1'b1; stepMode = stepSel; stepIn = 1'b0;
    tbClr = 1'b1;
    clocks(1);
    tbClr = 1'b0;
    clocks(2);
    check("R8 reset pc", 32'(imemAddr), 32'h0);
    check("R8 reset wr", 32'(dmemWr), 32'h0);
    check("R8 reset rd", 32'(dmemRd), 32'h0);
  endtask

  task automatic press();
    stepIn = 1'b1;
    clocks(8);
    stepIn = 1'b0;
    clocks(4);
  endtask

  task automatic testBasic();
    int w0, r0;
    enterReset(1'b0);
    poke(16'h0800, 8'h5A);
    poke(16'h0902, 8'h33);
    putInstr(0, 16'h0800, 16'h0900);
    putInstr(1, 16'h0900, 16'h0901);
    putInstr(2, 16'h0902, 16'h0902);
    w0 = wrCount; r0 = rdCount;
    rst = 1'b0;
    clocks(5);
    check("R6 no write before sixth clock", 32'(mem[12'h900]), 32'h00);
    clocks(1);
    check("R1 move copies byte", 32'(mem[12'h900]), 32'h5A);
    check("R3 pc after one instruction", 32'(imemAddr), 32'h4);
    clocks(6);
    check("R2 chained move sees prior result", 32'(mem[12'h901]), 32'h5A);
    clocks(6);
    check("R2 self move unchanged", 32'(mem[12'h902]), 32'h33);
    check("R6 pc after three instructions", 32'(imemAddr), 32'hC);
    check("R5 write pulses", 32'(wrCount - w0), 32'd3);
    check("R5 read pulses", 32'(rdCount - r0), 32'd3);
  endtask

  task automatic testCarry();
    enterReset(1'b0);
    for (int i = 0; i < 64; i++) putInstr(i, 16'h0800, 16'h0801);
    rst = 1'b0;
    clocks(63*6 + 4);
    check("R3 pc before carry", 32'(imemAddr), 32'h00FF);
    clocks(1);
    check("R3 pc carries into high half", 32'(imemAddr), 32'h0100);
  endtask

  task automatic testSelfMod();
    enterReset(1'b0);
    poke(16'h0A00, 8'h44);
    poke(16'h0B00, 8'h11);
    poke(16'h0B44, 8'h99);
    putInstr(0, 16'h0A00, 16'h0005);
    putInstr(1, 16'h0B00, 16'h0C00);
    rst = 1'b0;
    clocks(12);
    check("R9 patched source address used", 32'(mem[12'hC00]), 32'h99);
  endtask

  task automatic testStep();
    int w0, r0;
    enterReset(1'b1);
    poke(16'h0700, 8'hC3);
    putInstr(0, 16'h0700, 16'h0710);
    w0 = wrCount; r0 = rdCount;
    rst = 1'b0;
    clocks(10);
    check("R7 idle without press", 32'(imemAddr), 32'h0);
    press();
    check("R7 one press fetches source address", 32'(imemAddr), 32'h2);
    check("R7 long press counted once, no read yet", 32'(rdCount - r0), 32'd0);
    press();
    check("R7 read cycle keeps pc", 32'(imemAddr), 32'h2);
    check("R7 one read after second press", 32'(rdCount - r0), 32'd1);
    poke(16'h0700, 8'h0F);
    press();
    check("R7 destination fetch", 32'(imemAddr), 32'h4);
    check("R7 no write before fourth press", 32'(mem[12'h710]), 32'h00);
    press();
    check("R4 held value written", 32'(mem[12'h710]), 32'hC3);
    check("R5 one write in step mode", 32'(wrCount - w0), 32'd1);
    clocks(10);
    check("R7 stays put after cycle", 32'(imemAddr), 32'h4);
  endtask

  task automatic testResetMid();
    enterReset(1'b0);
    poke(16'h0600, 8'h77);
    putInstr(0, 16'h0600, 16'h0610);
    rst = 1'b0;
    clocks(5);
    rst = 1'b1;
    #1;
    check("R8 no write strobe under reset", 32'(dmemWr), 32'h0);
    clocks(3);
    check("R8 write suppressed by reset", 32'(mem[12'h610]), 32'h00);
    check("R8 pc cleared", 32'(imemAddr), 32'h0);
    rst = 1'b0;
    clocks(6);
    check("R8 restart from source fetch", 32'(mem[12'h610]), 32'h77);
    check("R8 pc after restarted instruction", 32'(imemAddr), 32'h4);
  endtask

  initial begin
    testBasic();
    testCarry();
    testSelfMod();
    testStep();
    testResetMid();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures + monFail);
    $finish;
  end

endmodule